// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory. A burst begins on either of two active-low start strobes: one driven by a processor, one by a cache or memory controller. On that edge the full input address is captured. Over the following cycles an active-low advance input steps the two low address bits through a four-beat sequence, while the upper bits stay fixed. The three chip-enable inputs must all be in their active state for a start to be taken.

A static order pin picks the beat sequence. With it low the low bits count upward from the start value and wrap after three. With it high each beat is the start value XOR a running beat count. A start strobe always wins over advance and may cut into a burst already under way. When there is neither a start nor an advance, the address holds, which suspends the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset is released, and before any start is taken, addr_out is all zeros.
- R2: On a rising edge where cpu_start_n or ctl_start_n is low and the chip enables are active, addr_out takes the addr_in value sampled at that edge.
- R3: The chip enables are active only when ce1_n is 0, ce2 is 1 and ce3_n is 0. A start strobe sampled with the enables in any other state leaves addr_out unchanged, provided adv_n is high.
- R4: A cpu_start_n strobe has no effect while ce1_n is high. When both strobes are low with the enables active, the address sampled in that cycle is loaded.
- R5: Between starts, addr_out bits above bit 1 keep the value they were loaded with, whatever adv_n and order_sel do.
- R6: With order_sel = 0, each advance sets addr_out[1:0] to (start + n) mod 4 for beat n = 1, 2, 3.
- R7: With order_sel = 1, each advance sets addr_out[1:0] to start XOR n for beat n = 1, 2, 3.
- R8: When a start is taken with adv_n also low, the load wins and beat 0 (the loaded address) appears. No advance is applied in that cycle.
- R9: A start taken in the middle of a burst reloads the address and restarts the sequence at beat 0.
- R10: With no start taken and adv_n high, addr_out holds its value.
- R11: The fourth advance after a start returns addr_out[1:0] to the start value, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | ADDR_W | Address sampled when a start is taken |
| cpu_start_n | input | 1 | Processor burst start, active low, gated by ce1_n |
| ctl_start_n | input | 1 | Controller burst start, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current array address |

## Verification
Every start, advance or hold decision acts on the address at the rising edge that samples it. The result is due one cycle after the stimulus, because addr_out comes straight from the registered base and beat with only the order mapping in between. The driver changes inputs just after a falling edge. It queues each expected address tagged with the cycle at which it falls due, and the monitor compares at the next falling edge, when that cycle is reached. Because order_sel reaches the output without a register, the mode is only ever changed after the monitor has taken its sample.

// File: rtl/bas_pkg.sv
package bas_pkg;

  // Beat counter width: four beats per burst
  localparam int BEAT_W   = 2;
  localparam int BEAT_CNT = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Linear order: add the beat count to the start offset, wrap naturally
  function automatic logic [BEAT_W-1:0] pos_linear(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    return start + beat;
  endfunction

  // Interleaved order: flip start offset bits by the beat count
  function automatic logic [BEAT_W-1:0] pos_interleave(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat
  );
    return start ^ beat;
  endfunction

  // Chip enables are active only in one combination
  function automatic logic enables_active(
    input logic ce1_n,
    input logic ce2,
    input logic ce3_n
  );
    return (!ce1_n) && ce2 && (!ce3_n);
  endfunction

endpackage

// File: rtl/bas_start_gate.sv
module bas_start_gate (
  input  logic cpu_start_n,
  input  logic ctl_start_n,
  input  logic adv_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output logic cpu_take,
  output logic ctl_take,
  output logic load,
  output logic step
);
  import bas_pkg::*;

  logic ce_ok;

  always_comb begin
    ce_ok    = enables_active(ce1_n, ce2, ce3_n);
    // processor strobe needs ce1_n low explicitly, and wins over controller
    cpu_take = (!cpu_start_n) && (!ce1_n) && ce_ok;
    ctl_take = (!ctl_start_n) && ce_ok && !cpu_take;
    load     = cpu_take || ctl_take;
    // advance applies only when no start is taken
    step     = (!adv_n) && !load;
  end

endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
  parameter int ADDR_W = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       step,
  input  logic [ADDR_W-1:0]          addr_in,
  output logic [ADDR_W-1:0]          base_q,
  output logic [bas_pkg::BEAT_W-1:0] beat_q
);
  import bas_pkg::*;

  logic [ADDR_W-1:0] base_d;
  logic [BEAT_W-1:0] beat_d;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    if (load) begin
      base_d = addr_in;
      beat_d = '0;
    end else if (step) begin
      beat_d = beat_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> base_q == $past(addr_in)); // R2
  AST_LOAD_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> beat_q == '0); // R9
  AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> beat_q == BEAT_W'($past(beat_q) + BEAT_W'(1))); // R6
  AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat_q)); // R10
  AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && step)); // R8

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map (
  input  logic [bas_pkg::BEAT_W-1:0] start_pos,
  input  logic [bas_pkg::BEAT_W-1:0] beat,
  input  logic                       order_sel,
  output logic [bas_pkg::BEAT_W-1:0] low_addr
);
  import bas_pkg::*;

  logic [BEAT_W-1:0] lin_pos;
  logic [BEAT_W-1:0] ilv_pos;

  always_comb begin
    lin_pos  = pos_linear(start_pos, beat);
    ilv_pos  = pos_interleave(start_pos, beat);
    low_addr = (order_e'(order_sel) == ORD_INTERLEAVE) ? ilv_pos : lin_pos;
  end

  // beat 0 must present the loaded offset in both orders
  always_comb begin
    if (beat == '0) begin
      AST_BEAT0_IS_START: assert (low_addr == start_pos); // R11
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out
);
  import bas_pkg::*;

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              cpu_take;
  logic              ctl_take;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_addr;

  bas_start_gate u_gate (
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .adv_n       (adv_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .ce3_n       (ce3_n),
    .cpu_take    (cpu_take),
    .ctl_take    (ctl_take),
    .load        (load),
    .step        (step)
  );

  bas_beat_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .addr_in (addr_in),
    .base_q  (base_q),
    .beat_q  (beat_q)
  );

  bas_order_map u_map (
    .start_pos (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .order_sel (order_sel),
    .low_addr  (low_addr)
  );

  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low_addr};

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ce1_n || !ce2 || ce3_n) && adv_n) |=> $stable(addr_out)); // R3
  AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce1_n && ctl_start_n && adv_n) |=> $stable(addr_out)); // R4
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])); // R5
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_take, ctl_take})); // R4

  if (UPPER_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed the beat width");
  end

endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          cpu_start_n = 1'b1;
  logic          ctl_start_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          ce1_n = 1'b0;
  logic          ce2 = 1'b1;
  logic          ce3_n = 1'b0;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit timed_out = 0;

  // bench model state
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  int            q_due[$];
  logic [AW-1:0] q_val[$];
  string         q_tag[$];

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .order_sel(order_sel),
    .addr_out(addr_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [AW-1:0] model_addr(input logic mode);
    int s, n;
    logic [1:0] lo;
    s = int'(m_base[1:0]);
    n = int'(m_beat);
    if (mode) lo = {m_base[1] ^ m_beat[1], m_base[0] ^ m_beat[0]};
    else      lo = 2'((s + n) % 4);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic drive(input logic cs, input logic ks, input logic av,
                       input logic e1, input logic e2, input logic e3,
                       input logic mode, input logic [AW-1:0] a,
                       input string tag);
    @(negedge clk);
    #1;
    cpu_start_n = cs; ctl_start_n = ks; adv_n = av;
    ce1_n = e1; ce2 = e2; ce3_n = e3; order_sel = mode; addr_in = a;
    if (!e1 && e2 && !e3 && (!cs || !ks)) begin
      m_base = a;
      m_beat = 2'd0;
    end else if (!av) begin
      m_beat = m_beat + 2'd1;
    end
    q_due.push_back(cyc + 1);
    q_val.push_back(model_addr(mode));
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      checks++;
      if (addr_out !== q_val[0]) begin
        errors++;
        $display("FAIL %s addr_out got %h expected %h", q_tag[0], addr_out, q_val[0]);
      end
      void'(q_due.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (addr_out !== '0) begin
      errors++;
      $display("FAIL R1 reset addr_out got %h expected %h", addr_out, '0);
    end
    // R2 controller start, linear, start offset 2
    drive(1, 0, 1, 0, 1, 0, 0, 18'h12342, "R2");
    // R6 linear advances, R5 upper bits held
    drive(1, 1, 0, 0, 1, 0, 0, 18'h00000, "R6");
    drive(1, 1, 0, 0, 1, 0, 0, 18'h3ffff, "R6");
    drive(1, 1, 0, 0, 1, 0, 0, 18'h00000, "R5");
    // R11 fourth advance wraps to start
    drive(1, 1, 0, 0, 1, 0, 0, 18'h00000, "R11");
    // R10 suspend
    drive(1, 1, 1, 0, 1, 0, 0, 18'h2aaaa, "R10");
    drive(1, 1, 1, 0, 1, 0, 0, 18'h15555, "R10");
    // R3 enables inactive: ce2 low, then ce3_n high
    drive(0, 0, 1, 0, 0, 0, 0, 18'h0abcd, "R3");
    drive(1, 0, 1, 0, 1, 1, 0, 18'h0bcde, "R3");
    // R4 processor strobe ignored while ce1_n high
    drive(0, 1, 1, 1, 1, 0, 0, 18'h0cdef, "R4");
    // R7 processor start, interleaved, start offset 1
    drive(0, 1, 1, 0, 1, 0, 1, 18'h2f0f1, "R7");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R11");
    // R9 reload mid-burst, interleaved start offset 3
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    drive(1, 0, 1, 0, 1, 0, 1, 18'h01237, "R9");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    drive(1, 1, 0, 0, 1, 0, 1, 18'h00000, "R7");
    // R8 start with advance low: load wins
    drive(0, 1, 0, 0, 1, 0, 0, 18'h3c001, "R8");
    drive(1, 1, 0, 0, 1, 0, 0, 18'h00000, "R6");
    // R4 both strobes low loads the sampled address
    drive(0, 0, 1, 0, 1, 0, 0, 18'h19993, "R4");
    drive(1, 1, 0, 0, 1, 0, 0, 18'h00000, "R6");
    // R3 gated strobe with advance: advance still steps
    drive(1, 0, 0, 0, 1, 1, 0, 18'h00002, "R3");
    drive(1, 1, 1, 0, 1, 0, 0, 18'h00000, "R10");
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule